// File: doc/BRIEF.md
# Serial Command Decoder and Register File

This block is the command side of a serially controlled data converter. A host drives chip select (active low), a serial clock and a data line into the block, and reads bytes back from a serial data output. Incoming bytes are decoded as commands. One-byte commands raise single-cycle pulses that ask the rest of the device to reset, start converting, stop converting, or shift out its latest conversion result. Two-byte commands read or write a run of consecutive registers in an eight-byte register file. That file holds an identity byte, a configuration byte, a 24-bit offset trim, a 16-bit gain trim and a mode byte, and it is also driven onto output ports for the converter to use.

The serial pins are oversampled by the block's own clock. Data are shifted most significant bit first. The data input is taken when the serial clock rises, and the data output moves after the serial clock falls. Releasing chip select at any point throws away the partly received byte and any half-finished command.

Top module: `spi_cmd_if`

## Requirements
- R1: After `rst_n` is released, `cfg_o` is 00h, `ofs_o` is 000000h, `gain_o` is 8000h (upper byte 80h), `mode_o` is `{mode_hi, 4'h0}` with `mode_hi` taken during reset, `dout` is 0, and no pulse output is high.
- R2: A command byte whose upper seven bits are 0000_011 (the last bit may be 0 or 1) gives one single-cycle `rst_pulse` and returns every writable register to its R1 value, with the mode byte taking the current `mode_hi`.
- R3: A byte matching 0000_100x gives one single-cycle `start_pulse`. A byte matching 0000_101x gives one single-cycle `stop_pulse`. The last bit is ignored, and at most one pulse output is high in any cycle.
- R4: The byte 0001_0010 gives one single-cycle `rdata_req`.
- R5: A read is 0010_aaaa followed by 0000_nnnn. Over the next nnnn+1 bytes the block sends out registers aaaa, aaaa+1, and so on, most significant bit first. Each bit appears on `dout` after a falling serial clock edge.
- R6: A write is 0100_aaaa, then 0000_nnnn, then nnnn+1 data bytes stored at aaaa, aaaa+1, and so on. Register addresses are: 0 identity, 1 configuration, 2–4 offset bytes 0–2 (`ofs_o` = {r4,r3,r2}), 5–6 gain bytes 0–1 (`gain_o` = {r6,r5}), 7 mode.
- R7: Register 0 always reads `{id_hi, 4'h3}`. Writes to it change nothing.
- R8: Addresses above 07h read back as 00h, and writes to them change nothing.
- R9: When `cs_n` is high, a partial byte and any partial command are dropped. The next byte after `cs_n` goes low is decoded as a new command.
- R10: A command byte that matches none of the codes above raises no pulse and changes no register. The byte after it is decoded as a command.
- R11: One clock after `cs_n` is high, `dout` is 0. While command bytes (not read data) are being shifted in, `dout` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, faster than the serial clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock, idles low |
| din | input | 1 | Serial data in |
| id_hi | input | 4 | Upper nibble of the identity register |
| mode_hi | input | 4 | Upper nibble of the mode register, loaded at reset |
| dout | output | 1 | Serial data out |
| rst_pulse | output | 1 | Device reset request pulse |
| start_pulse | output | 1 | Start conversion pulse |
| stop_pulse | output | 1 | Stop conversion pulse |
| rdata_req | output | 1 | Conversion data readout request pulse |
| cfg_o | output | 8 | Configuration register |
| ofs_o | output | 24 | Offset trim, three bytes |
| gain_o | output | 16 | Gain trim, two bytes |
| mode_o | output | 8 | Mode register |

## Verification
Each pulse command is sent with its last bit at both 0 and 1, which separates a full-byte compare from the intended seven-bit match. A full eight-register read after reset shows the reset values and the bit order at the same time. Reads and writes that start near address 7 and run past it show whether the address wraps or stops at the top. Transfers cut short by chip select, both in the middle of a byte and after a write header, show whether the decoder keeps stale state. In the second case, a stray write would turn the next command byte into register data.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
  localparam int BYTE_W  = 8;
  localparam int NREG    = 8;
  localparam int FIELD_W = 4;
  localparam int ADDR_W  = FIELD_W + 1;
  localparam int BCNT_W  = $clog2(BYTE_W);
  localparam logic [FIELD_W-1:0] ID_LO = 4'h3;

  typedef enum logic [2:0] {
    OP_NONE, OP_RESET, OP_START, OP_STOP, OP_RDATA, OP_RREG, OP_WREG
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RCNT, ST_WCNT, ST_RDAT, ST_WDAT
  } st_e;

  function automatic op_e classify(logic [BYTE_W-1:0] b);
    if (b[7:1] == 7'b0000_011)      return OP_RESET;
    else if (b[7:1] == 7'b0000_100) return OP_START;
    else if (b[7:1] == 7'b0000_101) return OP_STOP;
    else if (b == 8'h12)            return OP_RDATA;
    else if (b[7:4] == 4'h2)        return OP_RREG;
    else if (b[7:4] == 4'h4)        return OP_WREG;
    else                            return OP_NONE;
  endfunction

  function automatic logic [BYTE_W-1:0] reg_default(int idx, logic [FIELD_W-1:0] hi);
    case (idx)
      6:       return 8'h80;
      7:       return {hi, 4'h0};
      default: return '0;
    endcase
  endfunction

  function automatic logic [ADDR_W-1:0] field_addr(logic [BYTE_W-1:0] b);
    return {1'b0, b[FIELD_W-1:0]};
  endfunction
endpackage

// File: rtl/spi_bit_engine.sv
module spi_bit_engine
  import spi_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              din,
  input  logic              tx_en,
  input  logic [BYTE_W-1:0] tx_byte,
  output logic              dout,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              byte_done,
  output logic              fall_evt
);
  logic              sclk_q;
  logic [BYTE_W-1:0] shift_q;
  logic [BCNT_W-1:0] bcnt_q;
  logic              dout_q;
  logic              rise_evt;

  localparam logic [BCNT_W-1:0] LAST_BIT = BCNT_W'(BYTE_W - 1);

  assign rise_evt  = !cs_n && sclk && !sclk_q;
  assign fall_evt  = !cs_n && !sclk && sclk_q;
  assign byte_done = rise_evt && (bcnt_q == LAST_BIT);
  assign rx_byte   = {shift_q[BYTE_W-2:0], din};
  assign dout      = dout_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q  <= 1'b0;
      shift_q <= '0;
      bcnt_q  <= '0;
      dout_q  <= 1'b0;
    end else begin
      sclk_q <= sclk;
      if (cs_n) begin
        bcnt_q <= '0;
        dout_q <= 1'b0;
      end else begin
        if (rise_evt) begin
          shift_q <= rx_byte;
          bcnt_q  <= (bcnt_q == LAST_BIT) ? '0 : bcnt_q + 1'b1;
        end
        if (fall_evt)
          dout_q <= tx_en ? tx_byte[LAST_BIT - bcnt_q] : 1'b0;
      end
    end
  end
endmodule

// File: rtl/spi_cmd_decoder.sv
module spi_cmd_decoder
  import spi_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              byte_done,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic [BYTE_W-1:0] rd_data,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_data,
  output logic              tx_en,
  output logic [BYTE_W-1:0] tx_byte,
  output logic              dec_idle,
  output logic              rst_p,
  output logic              start_p,
  output logic              stop_p,
  output logic              rdata_p
);
  st_e               st_q;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] left_q;
  logic [BYTE_W-1:0] tx_q;
  op_e               op;

  assign op       = classify(rx_byte);
  assign rd_addr  = addr_q;
  assign wr_en    = byte_done && (st_q == ST_WDAT);
  assign wr_addr  = addr_q;
  assign wr_data  = rx_byte;
  assign tx_en    = (st_q == ST_RDAT);
  assign tx_byte  = tx_q;
  assign dec_idle = (st_q == ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      addr_q  <= '0;
      left_q  <= '0;
      tx_q    <= '0;
      rst_p   <= 1'b0;
      start_p <= 1'b0;
      stop_p  <= 1'b0;
      rdata_p <= 1'b0;
    end else begin
      rst_p   <= 1'b0;
      start_p <= 1'b0;
      stop_p  <= 1'b0;
      rdata_p <= 1'b0;
      if (cs_n) begin
        st_q <= ST_IDLE;
      end else if (byte_done) begin
        case (st_q)
          ST_IDLE: begin
            case (op)
              OP_RESET: rst_p   <= 1'b1;
              OP_START: start_p <= 1'b1;
              OP_STOP:  stop_p  <= 1'b1;
              OP_RDATA: rdata_p <= 1'b1;
              OP_RREG: begin
                addr_q <= field_addr(rx_byte);
                st_q   <= ST_RCNT;
              end
              OP_WREG: begin
                addr_q <= field_addr(rx_byte);
                st_q   <= ST_WCNT;
              end
              default: ;
            endcase
          end
          ST_RCNT: begin
            tx_q   <= rd_data;
            addr_q <= addr_q + 1'b1;
            left_q <= field_addr(rx_byte);
            st_q   <= ST_RDAT;
          end
          ST_WCNT: begin
            left_q <= field_addr(rx_byte);
            st_q   <= ST_WDAT;
          end
          ST_RDAT: begin
            if (left_q == '0) begin
              st_q <= ST_IDLE;
            end else begin
              tx_q   <= rd_data;
              addr_q <= addr_q + 1'b1;
              left_q <= left_q - 1'b1;
            end
          end
          ST_WDAT: begin
            addr_q <= addr_q + 1'b1;
            if (left_q == '0) st_q <= ST_IDLE;
            else              left_q <= left_q - 1'b1;
          end
          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/spi_reg_bank.sv
module spi_reg_bank
  import spi_cmd_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               soft_rst,
  input  logic [FIELD_W-1:0] id_hi,
  input  logic [FIELD_W-1:0] mode_hi,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [BYTE_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic [BYTE_W-1:0]  rd_data,
  output logic [BYTE_W-1:0]  cfg_o,
  output logic [3*BYTE_W-1:0] ofs_o,
  output logic [2*BYTE_W-1:0] gain_o,
  output logic [BYTE_W-1:0]  mode_o
);
  logic [BYTE_W-1:0] regs_q [1:NREG-1];

  for (genvar g = 1; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        regs_q[g] <= reg_default(g, mode_hi);
      else if (soft_rst)
        regs_q[g] <= reg_default(g, mode_hi);
      else if (wr_en && (wr_addr == ADDR_W'(g)))
        regs_q[g] <= wr_data;
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == '0) rd_data = {id_hi, ID_LO};
    for (int i = 1; i < NREG; i++)
      if (rd_addr == ADDR_W'(i)) rd_data = regs_q[i];
  end

  assign cfg_o  = regs_q[1];
  assign ofs_o  = {regs_q[4], regs_q[3], regs_q[2]};
  assign gain_o = {regs_q[6], regs_q[5]};
  assign mode_o = regs_q[7];
endmodule

// File: rtl/spi_cmd_if.sv
module spi_cmd_if
  import spi_cmd_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cs_n,
  input  logic        sclk,
  input  logic        din,
  input  logic [3:0]  id_hi,
  input  logic [3:0]  mode_hi,
  output logic        dout,
  output logic        rst_pulse,
  output logic        start_pulse,
  output logic        stop_pulse,
  output logic        rdata_req,
  output logic [7:0]  cfg_o,
  output logic [23:0] ofs_o,
  output logic [15:0] gain_o,
  output logic [7:0]  mode_o
);
  logic              byte_done;
  logic              fall_evt;
  logic [BYTE_W-1:0] rx_byte;
  logic              tx_en;
  logic [BYTE_W-1:0] tx_byte;
  logic [ADDR_W-1:0] rd_addr;
  logic [BYTE_W-1:0] rd_data;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [BYTE_W-1:0] wr_data;
  logic              dec_idle;

  spi_bit_engine u_bits (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din),
    .tx_en(tx_en), .tx_byte(tx_byte), .dout(dout), .rx_byte(rx_byte),
    .byte_done(byte_done), .fall_evt(fall_evt)
  );

  spi_cmd_decoder u_dec (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .byte_done(byte_done),
    .rx_byte(rx_byte), .rd_data(rd_data), .rd_addr(rd_addr),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .tx_en(tx_en), .tx_byte(tx_byte), .dec_idle(dec_idle),
    .rst_p(rst_pulse), .start_p(start_pulse), .stop_p(stop_pulse),
    .rdata_p(rdata_req)
  );

  spi_reg_bank u_regs (
    .clk(clk), .rst_n(rst_n), .soft_rst(rst_pulse), .id_hi(id_hi),
    .mode_hi(mode_hi), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .cfg_o(cfg_o), .ofs_o(ofs_o),
    .gain_o(gain_o), .mode_o(mode_o)
  );
endmodule

// File: rtl/spi_cmd_if_chk.sv
module spi_cmd_if_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       dout,
  input logic       rst_pulse,
  input logic       start_pulse,
  input logic       stop_pulse,
  input logic       rdata_req,
  input logic [7:0] cfg_o,
  input logic       fall_evt,
  input logic       dec_idle,
  input logic       wr_en,
  input logic [4:0] wr_addr
);
  // R3
  pulse_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rst_pulse, start_pulse, stop_pulse, rdata_req}));

  // R2
  rst_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_pulse |=> !rst_pulse);

  // R4
  rdata_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_req |=> !rdata_req);

  // R9
  abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> dec_idle);

  // R11
  dout_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> !dout);

  // R5
  dout_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(fall_evt) && !$past(cs_n)) |-> $stable(dout));

  // R6
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(wr_en && wr_addr == 5'd1) && !rst_pulse) |=> $stable(cfg_o));
endmodule

bind spi_cmd_if spi_cmd_if_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .dout(dout),
  .rst_pulse(rst_pulse), .start_pulse(start_pulse), .stop_pulse(stop_pulse),
  .rdata_req(rdata_req), .cfg_o(cfg_o), .fall_evt(fall_evt),
  .dec_idle(dec_idle), .wr_en(wr_en), .wr_addr(wr_addr)
);

// File: tb/tb_spi_cmd_if.sv
module tb_spi_cmd_if;
  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sclk = 1'b0, din = 1'b0;
  logic [3:0] id_hi = 4'h5, mode_hi = 4'hA;
  logic dout, rst_pulse, start_pulse, stop_pulse, rdata_req;
  logic [7:0] cfg_o, mode_o;
  logic [23:0] ofs_o;
  logic [15:0] gain_o;

  spi_cmd_if dut (.*);

  always #5 clk = ~clk;

  int total = 0, bad = 0;
  int n_rst = 0, n_start = 0, n_stop = 0, n_rd = 0;
  bit busy = 1'b1;
  bit done = 1'b0;
  logic [7:0] mdl [8];

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // pulse counters and the per-clock model compare
  always @(negedge clk) begin
    if (rst_n) begin
      if (rst_pulse)   n_rst++;
      if (start_pulse) n_start++;
      if (stop_pulse)  n_stop++;
      if (rdata_req)   n_rd++;
      if (!busy) begin
        chk("R6", "cfg_o", 32'(cfg_o), 32'(mdl[1]));
        chk("R6", "ofs_o", 32'(ofs_o), 32'({mdl[4], mdl[3], mdl[2]}));
        chk("R6", "gain_o", 32'(gain_o), 32'({mdl[6], mdl[5]}));
        chk("R6", "mode_o", 32'(mode_o), 32'(mdl[7]));
      end
    end
  end

  function automatic void mdl_defaults(logic [3:0] hi);
    for (int i = 0; i < 8; i++) mdl[i] = 8'h00;
    mdl[6] = 8'h80;
    mdl[7] = {hi, 4'h0};
  endfunction

  task automatic xfer_byte(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      @(negedge clk); sclk = 1'b0; din = tx[i];
      repeat (2) @(negedge clk);
      rx[i] = dout;
      sclk = 1'b1;
      @(negedge clk);
    end
  endtask

  task automatic send(input logic [7:0] q[$], output logic [7:0] r[$]);
    logic [7:0] b;
    busy = 1'b1;
    r = {};
    @(negedge clk); cs_n = 1'b0;
    repeat (2) @(negedge clk);
    foreach (q[k]) begin
      xfer_byte(q[k], b);
      r.push_back(b);
    end
    repeat (2) @(negedge clk);
    cs_n = 1'b1; sclk = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
    busy = 1'b0;
  endtask

  logic [7:0] rsp [$];
  int s0, p0, r0, d0;

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    mdl_defaults(mode_hi);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "cfg", 32'(cfg_o), 32'h00);
    chk("R1", "ofs", 32'(ofs_o), 32'h0);
    chk("R1", "gain", 32'(gain_o), 32'h8000);
    chk("R1", "mode", 32'(mode_o), 32'hA0);
    chk("R1", "dout", 32'(dout), 32'h0);
    chk("R1", "pulses", 32'({rst_pulse, start_pulse, stop_pulse, rdata_req}), 32'h0);
    busy = 1'b0;

    // R5 R7 full read from address 0
    send('{8'h20, 8'h07, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00}, rsp);
    chk("R7", "id read", 32'(rsp[2]), 32'h53);
    for (int a = 1; a < 8; a++) chk("R5", "read reg", 32'(rsp[2+a]), 32'(mdl[a]));
    chk("R11", "dout during header", 32'({rsp[0], rsp[1]}), 32'h0);
    settle();

    // R6 write three bytes at address 1
    send('{8'h41, 8'h02, 8'h11, 8'h22, 8'h33}, rsp);
    mdl[1] = 8'h11; mdl[2] = 8'h22; mdl[3] = 8'h33;
    settle();
    chk("R6", "cfg after write", 32'(cfg_o), 32'h11);

    // R7 write to id then cfg
    send('{8'h40, 8'h01, 8'hFF, 8'h44}, rsp);
    mdl[1] = 8'h44;
    settle();
    send('{8'h20, 8'h01, 8'h00, 8'h00}, rsp);
    chk("R7", "id unchanged", 32'(rsp[2]), 32'h53);
    chk("R5", "cfg readback", 32'(rsp[3]), 32'h44);
    settle();

    // R8 write running past 07h
    send('{8'h46, 8'h03, 8'h5A, 8'hC3, 8'h99, 8'h77}, rsp);
    mdl[6] = 8'h5A; mdl[7] = 8'hC3;
    settle();
    send('{8'h26, 8'h03, 8'h00, 8'h00, 8'h00, 8'h00}, rsp);
    chk("R8", "read 6", 32'(rsp[2]), 32'h5A);
    chk("R8", "read 7", 32'(rsp[3]), 32'hC3);
    chk("R8", "read 8", 32'(rsp[4]), 32'h00);
    chk("R8", "read 9", 32'(rsp[5]), 32'h00);
    settle();
    send('{8'h2E, 8'h01, 8'hFF, 8'hFF}, rsp);
    chk("R8", "read 0E/0F", 32'({rsp[2], rsp[3]}), 32'h0);
    settle();

    // R3 start and stop, both values of the last bit
    s0 = n_start; p0 = n_stop; r0 = n_rst; d0 = n_rd;
    send('{8'h08}, rsp);
    chk("R11", "dout on command", 32'(rsp[0]), 32'h0);
    send('{8'h09}, rsp);
    send('{8'h0A}, rsp);
    send('{8'h0B}, rsp);
    settle();
    chk("R3", "start count", n_start - s0, 2);
    chk("R3", "stop count", n_stop - p0, 2);
    chk("R3", "no other pulse", (n_rst - r0) + (n_rd - d0), 0);

    // R4 read-data request; R10 near miss 13h
    d0 = n_rd; s0 = n_start; p0 = n_stop;
    send('{8'h12}, rsp);
    send('{8'h13}, rsp);
    settle();
    chk("R4", "rdata count", n_rd - d0, 1);
    chk("R10", "13h no pulse", (n_start - s0) + (n_stop - p0), 0);

    // R10 unknown opcodes then a start in the same frame
    s0 = n_start; r0 = n_rst; p0 = n_stop;
    send('{8'hFF, 8'h00, 8'h08}, rsp);
    settle();
    chk("R10", "start after junk", n_start - s0, 1);
    chk("R10", "junk no pulse", (n_rst - r0) + (n_stop - p0), 0);

    // R9 abort inside a byte
    busy = 1'b1;
    @(negedge clk); cs_n = 1'b0;
    repeat (2) @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); sclk = 1'b0; din = 1'b1;
      repeat (2) @(negedge clk); sclk = 1'b1; @(negedge clk);
    end
    @(negedge clk); cs_n = 1'b1; sclk = 1'b0;
    repeat (2) @(negedge clk);
    chk("R11", "dout after cs high", 32'(dout), 32'h0);
    s0 = n_start;
    send('{8'h08}, rsp);
    settle();
    chk("R9", "start after partial byte", n_start - s0, 1);

    // R9 abort after write header: next byte must be a command, not data
    send('{8'h41, 8'h00}, rsp);
    p0 = n_stop;
    send('{8'h0A}, rsp);
    settle();
    chk("R9", "stop after aborted write", n_stop - p0, 1);
    chk("R9", "cfg kept", 32'(cfg_o), 32'h44);

    // R2 reset commands, both last-bit values, new mode nibble
    r0 = n_rst;
    send('{8'h06}, rsp);
    mdl_defaults(mode_hi);
    settle();
    chk("R2", "defaults", 32'({cfg_o, mode_o, gain_o}), 32'({8'h00, 8'hA0, 16'h8000}));
    busy = 1'b1;
    mode_hi = 4'h3;
    send('{8'h43, 8'h00, 8'h7E}, rsp);
    send('{8'h07}, rsp);
    mdl_defaults(mode_hi);
    settle();
    chk("R2", "reset count", n_rst - r0, 2);
    chk("R2", "offset cleared", 32'(ofs_o), 32'h0);
    chk("R2", "mode from pins", 32'(mode_o), 32'h30);

    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule